// File: doc/BRIEF.md
# NOR Flash Write-Buffer Burst Programmer

This block turns one burst request into the bus-write sequence a NOR flash needs in order to program several 16-bit words through its internal write buffer. A requester gives a start word address and a word count. The block then pulls the data words from a valid/ready stream and issues one write per cycle on a simple memory write port. The sequence is:

- the two-cycle unlock pair;
- the buffer-load command;
- the word count minus one;
- the data words;
- the confirm command.

The word address of the last data word loaded stays on an output after the burst ends, so that a separate status poller can read the flash at that location.

The block checks each request before it issues any cycle. It rejects a request with an error pulse when the count is zero, when the count is larger than the buffer, or when the burst would run past a buffer-aligned boundary. A request that arrives while a burst is in progress is refused with a busy pulse and leaves the running burst untouched.

Top module: `nor_wbuf_prog`

## Requirements
- R1: In the first cycle after a request is accepted, the block writes 0x00AA to word address 0x555. In the second cycle it writes 0x0055 to word address 0x2AA.
- R2: In the third cycle it writes 0x0025 to the start address. In the fourth cycle it writes count-1, zero-extended, to the start address.
- R3: Data words are written in stream order to start, start+1, ..., start+count-1. Each data write happens in a cycle where `wd_valid` and `wd_ready` are both high. `wd_ready` is high only during the data phase. A cycle in the data phase with `wd_valid` low issues no write.
- R4: In the cycle after the last data write, the block writes 0x0029 to start+count-1. `busy` is low in the following cycle.
- R5: A request with count 0, or with count greater than MAX_WORDS, is rejected. `req_err` is high for one cycle, in the cycle after the request, and no write is issued.
- R6: A request whose start offset within its MAX_WORDS-aligned block, plus count, exceeds MAX_WORDS is rejected in the same way as R5. `last_addr` is left unchanged.
- R7: A request presented while `busy` is high is refused. `req_refused` is high in the following cycle, and the running burst completes with exactly its own writes.
- R8: After a burst completes, `last_addr` holds start+count-1 until the data phase of the next accepted burst.
- R9: After reset, `busy`, `mem_we`, `wd_ready`, `req_err` and `req_refused` are low, and `last_addr` is 0.
- R10: A burst of exactly MAX_WORDS words from an aligned start address is accepted and completes. This holds even when the data stream stalls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Burst request strobe, sampled when idle |
| req_addr | input | AW | Start word address |
| req_count | input | CW | Number of words in the burst |
| req_err | output | 1 | One-cycle pulse: request rejected (count or boundary) |
| req_refused | output | 1 | One-cycle pulse: request arrived while busy |
| busy | output | 1 | Burst sequence in progress |
| wd_valid | input | 1 | Data word available |
| wd_data | input | DW | Data word |
| wd_ready | output | 1 | Data word taken when high with wd_valid |
| mem_we | output | 1 | Memory write strobe, one write per high cycle |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| last_addr | output | AW | Address of the last loaded data word |

## Verification
An accepted request makes `busy` and the first unlock write appear in the cycle after the request edge. Each command write then follows one cycle after the previous one. Each data write appears in the same cycle as its stream handshake, and the confirm write comes one cycle after the last handshake. `req_err` and `req_refused` appear exactly one cycle after the request edge. The bench drives inputs just after the rising edge and samples at the falling edge. It logs every write in the cycle where `mem_we` is high and compares the whole log against the expected sequence, so both a missing write and a stray write show up. Rejected and refused requests are checked at the pulse cycle, and afterwards through the write log and `last_addr`.

// File: rtl/nor_wbuf_prog.sv
module nor_wbuf_prog #(
  parameter int AW        = 24,
  parameter int DW        = 16,
  parameter int MAX_WORDS = 32,
  parameter int CW        = $clog2(MAX_WORDS + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [CW-1:0] req_count,
  output logic          req_err,
  output logic          req_refused,
  output logic          busy,
  input  logic          wd_valid,
  input  logic [DW-1:0] wd_data,
  output logic          wd_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] last_addr
);
  localparam int OW = $clog2(MAX_WORDS);
  localparam logic [AW-1:0] UNLOCK_A1 = AW'(12'h555);
  localparam logic [AW-1:0] UNLOCK_A2 = AW'(12'h2AA);
  localparam logic [DW-1:0] UNLOCK_D1 = DW'(8'hAA);
  localparam logic [DW-1:0] UNLOCK_D2 = DW'(8'h55);
  localparam logic [DW-1:0] LOAD_CMD  = DW'(8'h25);
  localparam logic [DW-1:0] CONF_CMD  = DW'(8'h29);

  typedef enum logic [2:0] {S_IDLE, S_UNL1, S_UNL2, S_LOAD, S_CNT, S_DATA, S_CONF} st_t;
  st_t state;

  logic [AW-1:0] start_q;
  logic [CW-1:0] cnt_m1_q, idx_q;
  logic [OW-1:0] off;
  logic          bad_cnt, bad_cross, take;
  logic [AW-1:0] data_addr;

  assign off       = req_addr[OW-1:0];
  assign bad_cnt   = (req_count == '0) || (req_count > CW'(MAX_WORDS));
  assign bad_cross = ((CW+1)'(off) + (CW+1)'(req_count)) > (CW+1)'(MAX_WORDS);
  assign busy      = (state != S_IDLE);
  assign wd_ready  = (state == S_DATA);
  assign take      = wd_ready && wd_valid;
  assign data_addr = start_q + AW'(idx_q);

  always_comb begin
    mem_we    = 1'b1;
    mem_addr  = start_q;
    mem_wdata = '0;
    unique case (state)
      S_UNL1:  begin mem_addr = UNLOCK_A1; mem_wdata = UNLOCK_D1; end
      S_UNL2:  begin mem_addr = UNLOCK_A2; mem_wdata = UNLOCK_D2; end
      S_LOAD:  mem_wdata = LOAD_CMD;
      S_CNT:   mem_wdata = DW'(cnt_m1_q);
      S_DATA:  begin mem_we = wd_valid; mem_addr = data_addr; mem_wdata = wd_data; end
      S_CONF:  begin mem_addr = last_addr; mem_wdata = CONF_CMD; end
      default: mem_we = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      start_q     <= '0;
      cnt_m1_q    <= '0;
      idx_q       <= '0;
      last_addr   <= '0;
      req_err     <= 1'b0;
      req_refused <= 1'b0;
    end else begin
      req_err     <= req_valid && !busy && (bad_cnt || bad_cross);
      req_refused <= req_valid && busy;
      unique case (state)
        S_IDLE: if (req_valid && !bad_cnt && !bad_cross) begin
          start_q  <= req_addr;
          cnt_m1_q <= req_count - 1'b1;
          idx_q    <= '0;
          state    <= S_UNL1;
        end
        S_UNL1: state <= S_UNL2;
        S_UNL2: state <= S_LOAD;
        S_LOAD: state <= S_CNT;
        S_CNT:  state <= S_DATA;
        S_DATA: if (take) begin
          last_addr <= data_addr;
          idx_q     <= idx_q + 1'b1;
          if (idx_q == cnt_m1_q) state <= S_CONF;
        end
        S_CONF: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/nor_wbuf_prog_chk.sv
module nor_wbuf_prog_chk #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          wd_ready,
  input logic          req_err,
  input logic          req_refused,
  input logic [AW-1:0] last_addr
);
  AST_FIRST_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (mem_we && mem_addr == AW'(12'h555) && mem_wdata == DW'(8'hAA))); // R1
  AST_SECOND_UNLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> (mem_we && mem_addr == AW'(12'h2AA) && mem_wdata == DW'(8'h55))); // R1
  AST_READY_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ready |-> busy); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we); // R5
  AST_REJECT_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> !busy); // R6
  AST_REFUSE_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_refused |-> $past(busy)); // R7
  AST_LAST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(last_addr)); // R8
endmodule

bind nor_wbuf_prog nor_wbuf_prog_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .wd_ready(wd_ready), .req_err(req_err),
  .req_refused(req_refused), .last_addr(last_addr)
);

// File: tb/sim_nor_wbuf_prog.sv
module sim_nor_wbuf_prog;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24, DW = 16, MAXW = 32;
  localparam int CW = $clog2(MAXW + 1) + 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, wd_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_count = '0;
  logic [DW-1:0] wd_data = '0;
  logic req_err, req_refused, busy, wd_ready, mem_we;
  logic [AW-1:0] mem_addr, last_addr;
  logic [DW-1:0] mem_wdata;

  int n_run = 0, n_fail = 0;
  logic [AW-1:0] log_a [0:255];
  logic [DW-1:0] log_d [0:255];
  int log_n = 0;

  nor_wbuf_prog #(.AW(AW), .DW(DW), .MAX_WORDS(MAXW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_count(req_count), .req_err(req_err), .req_refused(req_refused),
    .busy(busy), .wd_valid(wd_valid), .wd_data(wd_data), .wd_ready(wd_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .last_addr(last_addr));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (mem_we && log_n < 256) begin
    log_a[log_n] = mem_addr;
    log_d[log_n] = mem_wdata;
    log_n = log_n + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int seed, input int i);
    return DW'((seed << 8) ^ (i * 37 + 5));
  endfunction

  task automatic send_req(input logic [AW-1:0] a, input int c);
    @(posedge clk); #1;
    req_valid = 1; req_addr = a; req_count = CW'(c);
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic feed(input int c, input int seed, input bit stall);
    int i = 0, cyc = 0;
    bit took;
    forever begin
      @(negedge clk);
      if (!busy) break;
      took = wd_valid && wd_ready;
      @(posedge clk); #1;
      if (took) i++;
      cyc++;
      wd_valid = (i < c) && !(stall && (cyc % 3 == 1));
      wd_data  = pat(seed, i);
    end
    wd_valid = 0;
  endtask

  task automatic check_burst(input int base, input logic [AW-1:0] a, input int c, input int seed, input string tag);
    chk(log_n - base == c + 5, {tag, " write count"}, log_n - base, c + 5);
    chk(log_a[base] == 24'h555 && log_d[base] == 16'hAA, "R1 unlock1", log_d[base], 16'hAA);
    chk(log_a[base+1] == 24'h2AA && log_d[base+1] == 16'h55, "R1 unlock2", log_d[base+1], 16'h55);
    chk(log_a[base+2] == a && log_d[base+2] == 16'h25, "R2 load cmd", log_a[base+2], a);
    chk(log_a[base+3] == a && log_d[base+3] == DW'(c - 1), "R2 count-1", log_d[base+3], c - 1);
    for (int i = 0; i < c; i++)
      if (log_a[base+4+i] != a + AW'(i) || log_d[base+4+i] != pat(seed, i))
        chk(0, {tag, " R3 data word"}, log_d[base+4+i], pat(seed, i));
    chk(log_a[base+4+c] == a + AW'(c - 1) && log_d[base+4+c] == 16'h29, "R4 confirm",
        log_a[base+4+c], a + AW'(c - 1));
    chk(last_addr == a + AW'(c - 1), "R8 last_addr", last_addr, a + AW'(c - 1));
  endtask

  task automatic t_burst(input logic [AW-1:0] a, input int c, input int seed, input bit stall, input string tag);
    int base = log_n;
    send_req(a, c);
    feed(c, seed, stall);
    @(negedge clk);
    chk(!busy, "R4 busy low after confirm", busy, 0);
    check_burst(base, a, c, seed, tag);
  endtask

  task automatic t_reject(input logic [AW-1:0] a, input int c, input string tag);
    int base = log_n;
    logic [AW-1:0] la = last_addr;
    send_req(a, c);
    @(negedge clk);
    chk(req_err == 1, {tag, " req_err pulse"}, req_err, 1);
    chk(!busy, {tag, " no start"}, busy, 0);
    repeat (6) @(negedge clk);
    chk(log_n == base, {tag, " no writes"}, log_n - base, 0);
    chk(last_addr == la, {tag, " last_addr kept"}, last_addr, la);
    chk(!req_err, {tag, " req_err one cycle"}, req_err, 0);
  endtask

  task automatic t_refuse();
    int base = log_n;
    send_req(24'h000400, 6);
    fork
      feed(6, 9, 1);
      begin
        repeat (2) @(posedge clk);
        #1 req_valid = 1; req_addr = 24'h000800; req_count = CW'(3);
        @(posedge clk); #1 req_valid = 0;
        @(negedge clk);
        chk(req_refused == 1, "R7 refused pulse", req_refused, 1);
      end
    join
    @(negedge clk);
    check_burst(base, 24'h000400, 6, 9, "R7");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_we && !wd_ready, "R9 idle outputs", {busy, mem_we, wd_ready}, 0);
    chk(last_addr == 0 && !req_err && !req_refused, "R9 last_addr/pulses", last_addr, 0);
    t_burst(24'h000100, 4, 1, 0, "R3 short");
    t_burst(24'h000220, MAXW, 2, 1, "R10 full stalled");
    t_burst(24'h00003F, 1, 3, 0, "R4 single word");
    t_reject(24'h000000, 0, "R5 zero count");
    t_reject(24'h000000, MAXW + 1, "R5 over max");
    t_reject(24'h000105, 28, "R6 boundary cross");
    t_refuse();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule